// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block is the event-status, event-enable and control register file of a system power-management unit, together with a free-running power-management timer. Software reaches it over a byte-wide register bus with a combinational read path and a single-cycle write strobe. Hardware event inputs latch into sticky status flags. The timer sets a flag of its own whenever its most significant bit changes. Software clears flags by writing ones.

The block drives a level system-control interrupt. The interrupt is high while the interrupt-enable control bit is set and at least one interruptible status flag is set together with its matching enable bit. A write of the sleep-enable bit in the control register is not stored. Instead it produces a one-cycle sleep request that carries the 3-bit sleep type written alongside it. The sleep sequencing itself lies outside this block.

The timer advances once per cycle in which `tick_en` is high. The integration supplies that strobe at the nominal 3.579545 MHz rate, derived from the system clock.

Top module: `pm_event_regs`

## Requirements
- R1: After synchronous reset, status reads 0x0000, enable reads 0x0000, control reads 0x0001 (interrupt enable only) and the timer reads 0.
- R2: The timer increments by one on each clock in which `tick_en` is high and holds otherwise. It wraps modulo 2^TMR_W. It reads at byte offsets 8..11, least significant byte first, with bits above TMR_W reading 0.
- R3: When a timer increment changes the timer's most significant bit, in either direction, status bit 0 (timer overflow) is set.
- R4: A high level on an event input at a clock edge sets its status bit: bus master to bit 4, global to bit 5, power button to bit 8, RTC to bit 10, power-button override to bit 11, wake to bit 15. Status bits 1-3, 6, 7, 9 and 12-14 always read 0.
- R5: Status is write-one-to-clear. A write to offset 0 affects only bits 7:0 and a write to offset 1 affects only bits 15:8. Each 1 written clears the bit in that position, and each 0 leaves its bit unchanged.
- R6: If an event sets a status bit in the same cycle that software writes a 1 to clear it, the bit stays set.
- R7: The enable register sits at offsets 2 (bits 7:0) and 3 (bits 15:8). Only bits 0, 5, 8 and 10 are stored, and all other bits read 0.
- R8: `sci` is high exactly while control bit 0 is 1 and some status bit at position 0, 5, 8 or 10 is 1 together with the enable bit at the same position. Status bits 4, 11 and 15 never raise `sci`.
- R9: The control register sits at offsets 4 (bits 7:0) and 5 (bits 15:8). It stores bit 0 (interrupt enable), bit 2 (global release) and bits 12:10 (sleep type). Bit 13 (sleep enable) and all other bits read 0.
- R10: A write to offset 5 with data bit 5 set raises `sleep_req` for exactly the following cycle, with `sleep_type` equal to data bits 4:2 of that write. A write that does not set that bit raises no request.
- R11: Reads from offsets 6, 7 and 12..15 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Timer advance strobe |
| ev_busmaster | input | 1 | Bus-master activity event |
| ev_global | input | 1 | Global event |
| ev_pwrbtn | input | 1 | Power-button event |
| ev_rtc | input | 1 | RTC alarm event |
| ev_pbtn_ovr | input | 1 | Power-button override event |
| ev_wake | input | 1 | Wake event |
| sci | output | 1 | Level system-control interrupt |
| sleep_req | output | 1 | One-cycle sleep request |
| sleep_type | output | 3 | Sleep type carried by the last request |

## Verification
A hardware event and a software write-one-to-clear can hit the same status bit on the same clock edge. The bench provokes this by holding the power-button event high during the one cycle in which it writes 0x01 to the status high byte. It then reads that byte back and expects bit 8 to still be set. The bench also runs timer wraps across the most significant bit while the enable and interrupt-enable bits change. It judges `sci` against the gate computed from the bytes it wrote and the events it raised.

// File: rtl/pm_regs_pkg.sv
package pm_regs_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned LANES  = REG_W / BYTE_W;

    // byte offsets (enable two above status is fixed by the bus map)
    localparam logic [3:0] OFS_STS = 4'd0;
    localparam logic [3:0] OFS_EN  = 4'd2;
    localparam logic [3:0] OFS_CTL = 4'd4;
    localparam logic [3:0] OFS_TMR = 4'd8;

    // status bit positions
    localparam int unsigned B_TMROVF = 0;
    localparam int unsigned B_BUSMST = 4;
    localparam int unsigned B_GLOBAL = 5;
    localparam int unsigned B_PWRBTN = 8;
    localparam int unsigned B_RTC    = 10;
    localparam int unsigned B_PBOVR  = 11;
    localparam int unsigned B_WAKE   = 15;

    // control bit positions
    localparam int unsigned C_IRQEN  = 0;
    localparam int unsigned C_GREL   = 2;
    localparam int unsigned C_STYPLO = 10;
    localparam int unsigned C_SLPGO  = 13;
    localparam int unsigned STYP_W   = 3;

    localparam logic [REG_W-1:0] STS_KEEP = 16'h8D31;
    localparam logic [REG_W-1:0] EN_KEEP  = 16'h0521;
    localparam logic [REG_W-1:0] CTL_KEEP = 16'h1C05;
    localparam logic [REG_W-1:0] IRQ_SRC  = 16'h0521;
    localparam logic [REG_W-1:0] CTL_INIT = 16'h0001;

    typedef struct packed {
        logic wake;
        logic pbovr;
        logic rtc;
        logic pwrbtn;
        logic global_ev;
        logic busmst;
        logic tmrovf;
    } pm_events_t;

    function automatic logic [REG_W-1:0] events_to_vec(input pm_events_t e);
        logic [REG_W-1:0] v;
        v           = '0;
        v[B_TMROVF] = e.tmrovf;
        v[B_BUSMST] = e.busmst;
        v[B_GLOBAL] = e.global_ev;
        v[B_PWRBTN] = e.pwrbtn;
        v[B_RTC]    = e.rtc;
        v[B_PBOVR]  = e.pbovr;
        v[B_WAKE]   = e.wake;
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [31:0] w,
                                                    input logic [1:0] idx);
        return w[idx*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         msb_flip
);
    logic [W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt  = cnt + W'(1);
        msb_flip = tick & (cnt_nxt[W-1] ^ cnt[W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt_nxt;
    end
endmodule

// File: rtl/pm_status_reg.sv
module pm_status_reg
    import pm_regs_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP = STS_KEEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] clr_vec;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign clr_vec[l*BYTE_W +: BYTE_W] = lane_wr[l] ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= ((q & ~clr_vec) | set_vec) & KEEP;
    end
endmodule

// File: rtl/pm_lane_reg.sv
module pm_lane_reg
    import pm_regs_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP = EN_KEEP,
    parameter logic [REG_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [REG_W-1:0]  q
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [BYTE_W-1:0] LK = KEEP[l*BYTE_W +: BYTE_W];
        localparam logic [BYTE_W-1:0] LI = INIT[l*BYTE_W +: BYTE_W];
        always_ff @(posedge clk) begin
            if (rst)             q[l*BYTE_W +: BYTE_W] <= LI & LK;
            else if (lane_wr[l]) q[l*BYTE_W +: BYTE_W] <= wdata & LK;
        end
    end
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
    import pm_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned TMR_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tick_en,
    input  logic              ev_busmaster,
    input  logic              ev_global,
    input  logic              ev_pwrbtn,
    input  logic              ev_rtc,
    input  logic              ev_pbtn_ovr,
    input  logic              ev_wake,
    output logic              sci,
    output logic              sleep_req,
    output logic [2:0]        sleep_type
);
    localparam int unsigned PAD_W = 32 - TMR_W;

    logic [REG_W-1:0] sts_q, en_q, ctl_q, set_vec;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_flip;
    logic [LANES-1:0] sts_wr, en_wr, ctl_wr;
    logic [31:0]      tmr_word;
    pm_events_t       evs;

    // byte-lane write decode
    for (genvar l = 0; l < LANES; l++) begin : g_dec
        assign sts_wr[l] = bus_wr && (bus_addr == ADDR_W'(OFS_STS + 4'(l)));
        assign en_wr[l]  = bus_wr && (bus_addr == ADDR_W'(OFS_EN  + 4'(l)));
        assign ctl_wr[l] = bus_wr && (bus_addr == ADDR_W'(OFS_CTL + 4'(l)));
    end

    always_comb begin
        evs.tmrovf    = tmr_flip;
        evs.busmst    = ev_busmaster;
        evs.global_ev = ev_global;
        evs.pwrbtn    = ev_pwrbtn;
        evs.rtc       = ev_rtc;
        evs.pbovr     = ev_pbtn_ovr;
        evs.wake      = ev_wake;
        set_vec       = events_to_vec(evs);
    end

    pm_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .tick(tick_en),
        .cnt(tmr_cnt), .msb_flip(tmr_flip)
    );

    pm_status_reg #(.KEEP(STS_KEEP)) u_sts (
        .clk(clk), .rst(rst), .lane_wr(sts_wr), .wdata(bus_wdata),
        .set_vec(set_vec), .q(sts_q)
    );

    pm_lane_reg #(.KEEP(EN_KEEP), .INIT(16'h0000)) u_en (
        .clk(clk), .rst(rst), .lane_wr(en_wr), .wdata(bus_wdata), .q(en_q)
    );

    pm_lane_reg #(.KEEP(CTL_KEEP), .INIT(CTL_INIT)) u_ctl (
        .clk(clk), .rst(rst), .lane_wr(ctl_wr), .wdata(bus_wdata), .q(ctl_q)
    );

    // sleep strobe: the go bit lives in the high control byte
    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_req  <= 1'b0;
            sleep_type <= '0;
        end else begin
            sleep_req <= ctl_wr[1] && bus_wdata[C_SLPGO - BYTE_W];
            if (ctl_wr[1] && bus_wdata[C_SLPGO - BYTE_W])
                sleep_type <= bus_wdata[C_STYPLO - BYTE_W +: STYP_W];
        end
    end

    assign sci = ctl_q[C_IRQEN] && |(sts_q & en_q & IRQ_SRC);

    assign tmr_word = {{PAD_W{1'b0}}, tmr_cnt};

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(6)) begin
            case (bus_addr[2:1])
                2'd0:    bus_rdata = bus_addr[0] ? sts_q[15:8] : sts_q[7:0];
                2'd1:    bus_rdata = bus_addr[0] ? en_q[15:8]  : en_q[7:0];
                default: bus_rdata = bus_addr[0] ? ctl_q[15:8] : ctl_q[7:0];
            endcase
        end else if (bus_addr >= ADDR_W'(OFS_TMR) && bus_addr < ADDR_W'(OFS_TMR + 4'd4)) begin
            bus_rdata = pick_byte(tmr_word, bus_addr[1:0]);
        end
    end
endmodule

// File: rtl/pm_event_regs_chk.sv
module pm_event_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic        tick_en,
    input logic        ev_global,
    input logic        ev_pwrbtn,
    input logic [15:0] sts_q,
    input logic [15:0] en_q,
    input logic [15:0] ctl_q,
    input logic        sci,
    input logic        sleep_req,
    input logic        tmr_lsb
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (sts_q == 16'h0 && en_q == 16'h0 && ctl_q == 16'h0001));

    // R2
    tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(tmr_lsb));

    // R6
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_pwrbtn |=> sts_q[8]);

    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 4'd0 && bus_wdata[5] && !ev_global) |=> !sts_q[5]);

    // R8
    sci_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[0] |-> !sci);

    // R10
    slp_src_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> $past(bus_wr && bus_addr == 4'd5 && bus_wdata[5]));
endmodule

bind pm_event_regs pm_event_regs_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr[3:0]), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .tick_en(tick_en), .ev_global(ev_global),
    .ev_pwrbtn(ev_pwrbtn), .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q),
    .sci(sci), .sleep_req(sleep_req), .tmr_lsb(tmr_cnt[0])
);

// File: tb/pm_event_regs_bench.sv
`timescale 1ns/100ps
module pm_event_regs_bench;
    localparam int TW = 10;  // short timer so MSB flips are reachable

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0;
    logic       ev_busmaster = 0, ev_global = 0, ev_pwrbtn = 0;
    logic       ev_rtc = 0, ev_pbtn_ovr = 0, ev_wake = 0;
    logic       sci, sleep_req;
    logic [2:0] sleep_type;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pm_event_regs #(.ADDR_W(4), .TMR_W(TW)) u_pm_event_regs (.*);

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, e);
    endtask

    task automatic tick(input int n);
        @(negedge clk) tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // {addr, wdata, expected readback}
    localparam logic [19:0] VEC [0:7] = '{
        {4'd2, 8'hFF, 8'h21},  // R7 low enable byte keeps bits 0,5
        {4'd3, 8'hFF, 8'h05},  // R7 high enable byte keeps bits 8,10
        {4'd4, 8'hFF, 8'h05},  // R9 keeps bits 0,2
        {4'd5, 8'h1C, 8'h1C},  // R9 sleep type bits 12:10
        {4'd5, 8'hFF, 8'h1C},  // R9 bit 13 and above read 0
        {4'd6, 8'hFF, 8'h00},  // R11 hole
        {4'd0, 8'h00, 8'h00},  // R5 zero write leaves status
        {4'd4, 8'h01, 8'h01}   // R9 back to interrupt enable only
    };

    initial begin
        logic [7:0] v;
        do_reset();

        // R1 reset values
        rd_chk("R1 sts lo", 4'd0, 8'h00);
        rd_chk("R1 sts hi", 4'd1, 8'h00);
        rd_chk("R1 en lo", 4'd2, 8'h00);
        rd_chk("R1 en hi", 4'd3, 8'h00);
        rd_chk("R1 ctl lo", 4'd4, 8'h01);
        rd_chk("R1 ctl hi", 4'd5, 8'h00);
        rd_chk("R1 tmr", 4'd8, 8'h00);
        chk("R1 sci", sci, 0);

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd_chk("R7/R9/R11 table", VEC[i][19:16], VEC[i][7:0]);
        end

        // R11 writes to holes change nothing
        do_reset();
        wr(4'd7, 8'hFF);
        wr(4'd12, 8'hFF);
        rd_chk("R11 hole read", 4'd12, 8'h00);
        rd_chk("R11 ctl unchanged", 4'd4, 8'h01);
        rd_chk("R11 en unchanged", 4'd2, 8'h00);

        // R2 timer counting and hold
        tick(37);
        repeat (3) @(negedge clk);
        rd_chk("R2 tmr b0", 4'd8, 8'd37);
        rd_chk("R2 tmr b1", 4'd9, 8'd0);
        rd_chk("R2 tmr b3", 4'd11, 8'd0);

        // R3 overflow at MSB flip (bit 9 here)
        tick(474);
        rd_chk("R2 tmr 511 b0", 4'd8, 8'hFF);
        rd_chk("R2 tmr 511 b1", 4'd9, 8'h01);
        rd_chk("R3 no flag before flip", 4'd0, 8'h00);
        tick(1);
        rd_chk("R3 flag on 0->1 flip", 4'd0, 8'h01);
        chk("R8 no sci without enable", sci, 0);
        wr(4'd2, 8'h01);
        chk("R8 sci on tmr flag", sci, 1);
        wr(4'd4, 8'h00);
        chk("R8 sci gated by ctl", sci, 0);
        wr(4'd4, 8'h01);
        wr(4'd0, 8'h01);
        rd_chk("R5 clear tmr flag", 4'd0, 8'h00);
        chk("R8 sci drops", sci, 0);
        tick(512);
        rd_chk("R3 flag on 1->0 flip", 4'd0, 8'h01);
        rd_chk("R2 wrap b0", 4'd8, 8'h00);
        rd_chk("R2 wrap b1", 4'd9, 8'h00);

        // R4 events
        do_reset();
        @(negedge clk);
        ev_busmaster = 1; ev_global = 1; ev_pwrbtn = 1;
        ev_rtc = 1; ev_pbtn_ovr = 1; ev_wake = 1;
        @(negedge clk);
        ev_busmaster = 0; ev_global = 0; ev_pwrbtn = 0;
        ev_rtc = 0; ev_pbtn_ovr = 0; ev_wake = 0;
        rd_chk("R4 sts lo", 4'd0, 8'h30);
        rd_chk("R4 sts hi", 4'd1, 8'h8D);
        chk("R8 no sci with zero enable", sci, 0);

        // R5 byte lanes
        wr(4'd1, 8'h01);
        rd_chk("R5 hi cleared bit8", 4'd1, 8'h8C);
        rd_chk("R5 lo untouched", 4'd0, 8'h30);
        wr(4'd0, 8'h10);
        rd_chk("R5 clear bit4", 4'd0, 8'h20);

        // R8 gating per source
        wr(4'd2, 8'h20);
        chk("R8 sci global", sci, 1);
        wr(4'd0, 8'h20);
        chk("R8 sci after clear", sci, 0);
        wr(4'd3, 8'h04);
        chk("R8 sci rtc", sci, 1);
        wr(4'd1, 8'hFF);
        rd_chk("R5 hi all cleared", 4'd1, 8'h00);
        chk("R8 sci off", sci, 0);
        @(negedge clk) ev_wake = 1;
        @(negedge clk) ev_wake = 0;
        chk("R8 wake never raises sci", sci, 0);

        // R6 set wins over clear
        @(negedge clk);
        ev_pwrbtn = 1; bus_addr = 4'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        ev_pwrbtn = 0; bus_wr = 1'b0;
        rd_chk("R6 set beats clear", 4'd1, 8'h81);

        // R10 sleep strobe
        chk("R10 idle", sleep_req, 0);
        @(negedge clk);
        bus_addr = 4'd5; bus_wdata = 8'h34; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 pulse", sleep_req, 1);
        chk("R10 type", sleep_type, 5);
        @(negedge clk);
        chk("R10 one cycle", sleep_req, 0);
        rd_chk("R9 go bit reads 0", 4'd5, 8'h14);
        @(negedge clk);
        bus_addr = 4'd5; bus_wdata = 8'h14; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 no pulse without go", sleep_req, 0);
        @(negedge clk);
        bus_addr = 4'd4; bus_wdata = 8'h20; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10 low byte bit5 no pulse", sleep_req, 0);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule